// File: doc/BRIEF.md
# E1 Signalling Multiframe Aligner

This block locates and follows the 16-frame channel-associated-signalling multiframe of an E1 stream. Once per basic frame, an upstream frame aligner presents the time-slot-16 octet together with a one-cycle strobe. The aligner looks for a zero upper nibble to find frame 0 of the multiframe, and it counts frames from that point.

Its outputs are a lock flag, a confirmation flag, the frame number of the octet just received, the far-end multiframe alarm (Y) bit, and the two voice-channel numbers whose ABCD nibbles that octet carries. The phase is kept only here, so the signalling boundary can sit at any offset from a CRC-4 multiframe.

Top module: `cas_mf_align`

## Requirements
- R1: While unlocked, a strobed octet whose upper nibble (`ts16[7:4]`) is 0000 sets `mf_lock` on the following clock edge, with `mf_frame` = 0. Any other upper nibble leaves the block unlocked.
- R2: After lock is first declared, the next expected frame 0 (the 16th strobe later) sets `mf_conf` if that octet shows 0000 in its upper nibble. If it does not, the block returns to the unlocked state.
- R3: While locked, each strobe advances `mf_frame` by one, modulo 16.
- R4: `far_y` takes `ts16[2]` (bit 6 when the bits are counted 1 to 8 from the MSB) from every accepted frame-0 octet. It keeps its value through the other frames and through a failed frame 0, and it is 0 while unlocked.
- R5: Once confirmed, lock is lost only after two consecutive expected frame-0 octets fail the pattern. A single failure followed by a good frame 0 keeps lock.
- R6: While locked in frame n, where n is 1 to 15, `ch_upper` = n and `ch_lower` = n+15. In frame 0 and while unlocked, both are 0.
- R7: While locked, a zero upper nibble in frames 1 to 15 neither realigns the count nor drops lock.
- R8: Cycles without a strobe change no output, whatever the value on `ts16`.
- R9: After reset the block is unlocked and unconfirmed, and `mf_frame`, `far_y`, `ch_upper` and `ch_lower` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe per basic frame, qualifying ts16 |
| ts16 | input | 8 | Time-slot-16 octet, MSB first on bit 7 |
| mf_lock | output | 1 | Multiframe lock declared |
| mf_conf | output | 1 | Lock confirmed by a second frame 0 |
| mf_frame | output | 4 | Frame number of the last strobed octet |
| far_y | output | 1 | Received far-end multiframe alarm bit |
| ch_upper | output | 5 | Channel carried in the upper nibble |
| ch_lower | output | 5 | Channel carried in the lower nibble |

## Verification
While the block hunts, every one of the 15 nonzero upper nibbles is sent, and none of them may cause a lock. A zero octet held without a strobe must not lock the block either. Complete multiframes are then walked frame by frame, and the frame count and both channel numbers are checked against values computed arithmetically. A zero nibble placed in frame 7 tells a false realignment apart from correct tracking. Frame-0 failure sequences are also tried: a single miss, a miss then a good frame 0, two misses in a row, and a miss during confirmation. Together these separate the loss threshold from the confirmation rule, and the Y bit is varied so that capture can be told apart from holding.

// File: rtl/cas_mf_align.sv
module cas_mf_align #(
  parameter int MISS_MAX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_stb,
  input  logic [7:0] ts16,
  output logic       mf_lock,
  output logic       mf_conf,
  output logic [3:0] mf_frame,
  output logic       far_y,
  output logic [4:0] ch_upper,
  output logic [4:0] ch_lower
);
  localparam int MW = $clog2(MISS_MAX + 1);

  typedef enum logic [1:0] {HUNT, CHECK, SYNC} st_t;

  st_t         st;
  logic [3:0]  frame;
  logic [MW-1:0] miss;
  logic        y;

  wire       zero_nib = (ts16[7:4] == 4'h0);
  wire [3:0] nxt      = frame + 4'd1;
  wire       at0      = (nxt == 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= HUNT;
      frame <= 4'd0;
      y     <= 1'b0;
      miss  <= '0;
    end else if (frm_stb) begin
      case (st)
        HUNT: if (zero_nib) begin
          st    <= CHECK;
          frame <= 4'd0;
          y     <= ts16[2];
          miss  <= '0;
        end
        CHECK: begin
          frame <= nxt;
          if (at0) begin
            if (zero_nib) begin
              st <= SYNC;
              y  <= ts16[2];
            end else begin
              st    <= HUNT;
              frame <= 4'd0;
              y     <= 1'b0;
            end
          end
        end
        SYNC: begin
          frame <= nxt;
          if (at0) begin
            if (zero_nib) begin
              miss <= '0;
              y    <= ts16[2];
            end else if (miss == MW'(MISS_MAX - 1)) begin
              st    <= HUNT;
              frame <= 4'd0;
              y     <= 1'b0;
              miss  <= '0;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
        default: st <= HUNT;
      endcase
    end
  end

  assign mf_lock  = (st != HUNT);
  assign mf_conf  = (st == SYNC);
  assign mf_frame = frame;
  assign far_y    = y;
  assign ch_upper = (mf_lock && frame != 4'd0) ? {1'b0, frame} : 5'd0;
  assign ch_lower = (mf_lock && frame != 4'd0) ? {1'b0, frame} + 5'd15 : 5'd0;
endmodule

// File: rtl/cas_mf_align_chk.sv
module cas_mf_align_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_stb,
  input logic [7:0] ts16,
  input logic       mf_lock,
  input logic       mf_conf,
  input logic [3:0] mf_frame,
  input logic       far_y,
  input logic [4:0] ch_upper,
  input logic [4:0] ch_lower
);
  AST_LOCK_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_lock && frm_stb && ts16[7:4] == 4'h0) |=> (mf_lock && mf_frame == 4'd0)); // R1
  AST_NO_FALSE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_lock && frm_stb && ts16[7:4] != 4'h0) |=> !mf_lock); // R1
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_lock && frm_stb) |=> (!mf_lock || mf_frame == $past(mf_frame) + 4'd1)); // R3
  AST_Y_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_lock && frm_stb && ts16[7:4] == 4'h0) |=> (far_y == $past(ts16[2]))); // R4
  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lock |-> (!mf_conf && !far_y && mf_frame == 4'd0 && ch_upper == 5'd0)); // R9
  AST_CHAN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_lock && mf_frame != 4'd0) |-> (ch_lower == ch_upper + 5'd15 && ch_upper == {1'b0, mf_frame})); // R6
  AST_DROP_ONLY_AT_F0: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_lock && frm_stb && mf_frame != 4'd15) |=> mf_lock); // R7
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_stb |=> ($stable(mf_lock) && $stable(mf_conf) && $stable(mf_frame) && $stable(far_y))); // R8
endmodule

bind cas_mf_align cas_mf_align_chk u_chk (.*);

// File: tb/sim_cas_mf_align.sv
module sim_cas_mf_align;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_stb = 1'b0;
  logic [7:0] ts16 = 8'h00;
  logic mf_lock, mf_conf, far_y;
  logic [3:0] mf_frame;
  logic [4:0] ch_upper, ch_lower;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cas_mf_align u0 (.*);

  task automatic chk(input string tag, input logic lk, input logic cf,
                     input logic [3:0] fn, input logic y);
    logic [4:0] eu, el;
    eu = (lk && fn != 0) ? {1'b0, fn} : 5'd0;
    el = (lk && fn != 0) ? {1'b0, fn} + 5'd15 : 5'd0;
    checks++;
    if (mf_lock !== lk || mf_conf !== cf || mf_frame !== fn || far_y !== y ||
        ch_upper !== eu || ch_lower !== el) begin
      errors++;
      $display("FAIL %s: got lock=%0b conf=%0b frame=%0d y=%0b up=%0d lo=%0d exp %0b %0b %0d %0b %0d %0d",
               tag, mf_lock, mf_conf, mf_frame, far_y, ch_upper, ch_lower, lk, cf, fn, y, eu, el);
    end
  endtask

  task automatic tx(input logic [7:0] o);
    @(negedge clk);
    frm_stb = 1'b1;
    ts16 = o;
    @(negedge clk);
    frm_stb = 1'b0;
    ts16 = 8'h00;
  endtask

  function automatic logic [7:0] f0(input logic y);
    return {4'h0, 1'b1, y, 2'b11};
  endfunction

  task automatic mid(input string tag, input logic cf, input logic y, input bit zero7);
    for (int k = 1; k < 16; k++) begin
      tx((zero7 && k == 7) ? 8'h0F : {4'(k), 4'h5});
      chk(tag, 1'b1, cf, 4'(k), y);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset", 0, 0, 0, 0);

    for (int n = 1; n < 16; n++) begin
      tx({4'(n), 4'h0});
      chk("R1 nonzero nibble", 0, 0, 0, 0);
    end

    ts16 = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 no strobe while hunting", 0, 0, 0, 0);

    tx(f0(1'b1));
    chk("R1 lock on zero nibble", 1, 0, 0, 1);
    mid("R7 R6 R3 first multiframe", 1'b0, 1'b1, 1'b1);
    tx(f0(1'b0));
    chk("R2 confirm R4 y", 1, 1, 0, 0);

    repeat (4) @(negedge clk);
    chk("R8 no strobe while locked", 1, 1, 0, 0);

    mid("R3 R6 second multiframe", 1'b1, 1'b0, 1'b0);
    tx(f0(1'b1));
    chk("R4 y capture", 1, 1, 0, 1);
    mid("R3 third multiframe", 1'b1, 1'b1, 1'b0);
    tx(8'h80);
    chk("R5 single miss holds lock R4 y held", 1, 1, 0, 1);
    mid("R5 after miss", 1'b1, 1'b1, 1'b0);
    tx(f0(1'b0));
    chk("R5 recover after single miss", 1, 1, 0, 0);
    mid("R5 pre double miss", 1'b1, 1'b0, 1'b0);
    tx(8'h90);
    chk("R5 first of two misses", 1, 1, 0, 0);
    mid("R5 between misses", 1'b1, 1'b0, 1'b1);
    tx(8'hA4);
    chk("R5 loss after two misses", 0, 0, 0, 0);

    tx(8'h04);
    chk("R1 relock R4 y", 1, 0, 0, 1);
    mid("R2 pending confirm", 1'b0, 1'b1, 1'b0);
    tx(8'hB0);
    chk("R2 failed confirm returns to hunt", 0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule